// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Pair

This block performs 32-bit integer multiplication and division over many cycles. It does not write a general register. Instead it fills a dedicated pair of result registers, HI and LO. A multiply splits its 64-bit product across the two registers. A divide puts the quotient in one register and the remainder in the other.

A pipeline launches an operation with a one-cycle `start` pulse, together with a 2-bit operation code and two operands. The unit then holds `busy` high while it runs one shift-add or restoring-subtract step per cycle. The two registers are read through a single port, and `rd_hi` selects which one is returned. A read requested while the unit is busy raises `rd_stall`, and the reader holds until the result lands. Both signed (two's complement) and unsigned operand handling are supported. Division by zero completes normally and returns a fixed pattern instead of trapping.

Top module: `muldiv_hilo`

## Requirements
- R1: With `op` = 2'b00 (signed multiply), both operands are read as two's complement when the operation completes. LO then holds bits 31:0 of the 64-bit product and HI holds bits 63:32.
- R2: With `op` = 2'b01 (unsigned multiply), both operands are read as unsigned. The full 64-bit product is split the same way: low word to LO, high word to HI.
- R3: With `op` = 2'b10 (signed divide), the quotient is truncated toward zero and written to LO. The remainder is written to HI and carries the sign of the dividend. The case 0x80000000 / 0xFFFFFFFF returns LO = 0x80000000 and HI = 0.
- R4: With `op` = 2'b11 (unsigned divide), the unsigned quotient is written to LO and the unsigned remainder to HI.
- R5: A divide, signed or unsigned, with a zero divisor completes without any error indication. It leaves LO = 0xFFFFFFFF and HI equal to the unmodified dividend.
- R6: A `start` pulse while idle is accepted at that clock edge. `busy` is then high for exactly 32 cycles. The new HI/LO values are visible in the cycle in which `busy` has returned low.
- R7: A `start` pulse while `busy` is high is ignored. The running operation finishes with results computed from its original operands and code.
- R8: `rd_data` returns HI when `rd_hi` = 1 and LO when `rd_hi` = 0. `rd_stall` is high exactly when `rd_en` is high while the unit is busy.
- R9: After reset, `busy` is low and both HI and LO read as zero.
- R10: While idle and with no `start`, HI and LO keep their values indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse, accepted only when idle |
| op | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| src_a | input | 32 | Multiplicand or dividend |
| src_b | input | 32 | Multiplier or divisor |
| busy | output | 1 | High while an operation is in progress |
| rd_en | input | 1 | Read request for HI or LO |
| rd_hi | input | 1 | Selects HI (1) or LO (0) for `rd_data` |
| rd_data | output | 32 | Selected result register |
| rd_stall | output | 1 | Read requested while busy; reader must wait |

## Verification
The bench targets the sign-handling corners. These are negative-by-negative and mixed-sign products, divisions where only the dividend or only the divisor is negative, and the most-negative-by-minus-one divide. A unit that fixed the sign from the wrong operand would return a remainder with the wrong sign or a product negated by mistake. Both kinds of divide by zero are driven, along with all-ones unsigned operands. A unit that applied sign correction to the zero-divisor pattern would return 1 instead of all ones. A unit that truncated the high product word would lose HI. Further checks cover a second `start` issued mid-operation, which must not disturb the result, and reads during the busy window, which must report a stall.

// File: rtl/muldiv_hilo.sv
module muldiv_hilo #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  output logic         busy,
  input  logic         rd_en,
  input  logic         rd_hi,
  output logic [W-1:0] rd_data,
  output logic         rd_stall
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  hi, lo;
  logic [W-1:0]  rh, rl, bm, a_keep;
  logic [CW-1:0] cnt;
  logic          is_div, neg_q, neg_r, dz;

  wire           go     = start & ~busy;
  wire           sgn_in = ~op[0];
  wire [W-1:0]   mag_a  = (sgn_in & src_a[W-1]) ? -src_a : src_a;
  wire [W-1:0]   mag_b  = (sgn_in & src_b[W-1]) ? -src_b : src_b;

  wire [W:0]     msum   = {1'b0, rh} + (rl[0] ? {1'b0, bm} : '0);
  wire [W-1:0]   mh_n   = msum[W:1];
  wire [W-1:0]   ml_n   = {msum[0], rl[W-1:1]};

  wire [W:0]     trial  = {rh, rl[W-1]} - {1'b0, bm};
  wire           fits   = ~trial[W];
  wire [W-1:0]   dh_n   = fits ? trial[W-1:0] : {rh[W-2:0], rl[W-1]};
  wire [W-1:0]   dl_n   = {rl[W-2:0], fits};

  wire [W-1:0]   rh_n   = is_div ? dh_n : mh_n;
  wire [W-1:0]   rl_n   = is_div ? dl_n : ml_n;

  wire [2*W-1:0] prod   = {mh_n, ml_n};
  wire [2*W-1:0] prod_f = neg_q ? -prod : prod;
  wire [W-1:0]   quo_f  = dz ? '1 : (neg_q ? -dl_n : dl_n);
  wire [W-1:0]   rem_f  = dz ? a_keep : (neg_r ? -dh_n : dh_n);

  assign rd_data  = rd_hi ? hi : lo;
  assign rd_stall = rd_en & busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      hi     <= '0;
      lo     <= '0;
      rh     <= '0;
      rl     <= '0;
      bm     <= '0;
      a_keep <= '0;
      is_div <= 1'b0;
      neg_q  <= 1'b0;
      neg_r  <= 1'b0;
      dz     <= 1'b0;
    end else if (go) begin
      busy   <= 1'b1;
      cnt    <= '0;
      rh     <= '0;
      rl     <= mag_a;
      bm     <= mag_b;
      a_keep <= src_a;
      is_div <= op[1];
      neg_q  <= sgn_in & (src_a[W-1] ^ src_b[W-1]);
      neg_r  <= sgn_in & src_a[W-1];
      dz     <= op[1] & (src_b == '0);
    end else if (busy) begin
      rh  <= rh_n;
      rl  <= rl_n;
      cnt <= cnt + 1'b1;
      if (cnt == LAST) begin
        busy <= 1'b0;
        hi   <= is_div ? rem_f : prod_f[2*W-1:W];
        lo   <= is_div ? quo_f : prod_f[W-1:0];
      end
    end
  end

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && cnt == '0);                              // R6
  AST_STEP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cnt != LAST |=> busy && cnt == $past(cnt) + 1'b1);          // R6
  AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(bm) && $stable(is_div) && $stable(neg_q)); // R7
  AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    busy && dz && cnt == LAST |=> lo == '1 && hi == $past(a_keep));     // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(hi) && $stable(lo));                   // R10
  AST_STALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stall |-> busy);                                                 // R8
endmodule

// File: tb/tb_muldiv_hilo.sv
module tb_muldiv_hilo;
  logic        clk = 0, rst_n = 0, start = 0, rd_en = 0, rd_hi = 0;
  logic [1:0]  op = 0;
  logic [31:0] src_a = 0, src_b = 0, rd_data;
  logic        busy, rd_stall;
  int          n_chk = 0, n_fail = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  muldiv_hilo dut (.clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .src_a(src_a), .src_b(src_b), .busy(busy), .rd_en(rd_en), .rd_hi(rd_hi),
    .rd_data(rd_data), .rd_stall(rd_stall));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
    longint q, r;
    logic [63:0] p;
    case (o)
      2'b00: p = 64'(longint'($signed(a)) * longint'($signed(b)));
      2'b01: p = {32'b0, a} * {32'b0, b};
      2'b10: begin
        if (b == 0) p = {a, 32'hFFFFFFFF};
        else begin
          q = longint'($signed(a)) / longint'($signed(b));
          r = longint'($signed(a)) % longint'($signed(b));
          p = {r[31:0], q[31:0]};
        end
      end
      default: p = (b == 0) ? {a, 32'hFFFFFFFF} : {a % b, a / b};
    endcase
    return p;
  endfunction

  task automatic run_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                        input string tag, input bit poke);
    @(negedge clk);
    exp_q.push_back(model(o, a, b));
    tag_q.push_back(tag);
    op = o; src_a = a; src_b = b; start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (3) @(negedge clk);
      op = ~o; src_a = ~a; src_b = b + 32'd7; start = 1;
      @(negedge clk);
      start = 0;
    end
    while (busy) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  initial begin : monitor
    logic [63:0] e;
    string t;
    bit prev = 0;
    wait (rst_n);
    forever begin
      @(negedge clk);
      if (prev && !busy) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        rd_en = 0; rd_hi = 0; #1;
        chk(rd_data == e[31:0], {t, " LO"}, rd_data, e[31:0]);
        rd_hi = 1; #1;
        chk(rd_data == e[63:32], {t, " HI"}, rd_data, e[63:32]);
        repeat (6) @(negedge clk);
        rd_hi = 0; #1;
        chk(rd_data == e[31:0], "R10 LO held", rd_data, e[31:0]);
        rd_hi = 1; #1;
        chk(rd_data == e[63:32], "R10 HI held", rd_data, e[63:32]);
      end else if (!prev && busy) begin
        rd_en = 1; #1;
        chk(rd_stall == 1'b1, "R8 stall while busy", 32'(rd_stall), 32'd1);
        rd_en = 0; #1;
        chk(rd_stall == 1'b0, "R8 no stall without request", 32'(rd_stall), 32'd0);
      end
      prev = busy;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : driver
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 1'b0, "R9 busy after reset", 32'(busy), 32'd0);
    rd_hi = 0; #1;
    chk(rd_data == 0, "R9 LO after reset", rd_data, 0);
    rd_hi = 1; #1;
    chk(rd_data == 0, "R9 HI after reset", rd_data, 0);

    // R6: measure busy length
    @(negedge clk);
    exp_q.push_back(model(2'b01, 32'd3, 32'd5)); tag_q.push_back("R6 latency");
    op = 2'b01; src_a = 3; src_b = 5; start = 1;
    @(negedge clk); start = 0; cyc = 1;
    while (busy) begin @(negedge clk); if (busy) cyc++; end
    chk(cyc == 32, "R6 busy cycles", cyc, 32);
    repeat (8) @(negedge clk);

    run_op(2'b00, 32'hFFFFFFF9, 32'h00000006, "R1 neg*pos", 0);
    run_op(2'b00, 32'h80000000, 32'h80000000, "R1 min*min", 0);
    run_op(2'b00, 32'h12345678, 32'hFEDCBA98, "R1 mixed", 0);
    run_op(2'b01, 32'hFFFFFFFF, 32'hFFFFFFFF, "R2 ones*ones", 0);
    run_op(2'b01, 32'h89ABCDEF, 32'h00010001, "R2 mixed", 0);
    run_op(2'b10, 32'hFFFFFFF9, 32'h00000002, "R3 neg/pos", 0);
    run_op(2'b10, 32'h00000007, 32'hFFFFFFFE, "R3 pos/neg", 0);
    run_op(2'b10, 32'h80000000, 32'hFFFFFFFF, "R3 min/-1", 0);
    run_op(2'b10, 32'hFFFFFF00, 32'hFFFFFFF3, "R3 neg/neg", 0);
    run_op(2'b11, 32'hFFFFFFFF, 32'h00000007, "R4 big/7", 0);
    run_op(2'b11, 32'h00000005, 32'h80000000, "R4 small/big", 0);
    run_op(2'b10, 32'hFFFFFF85, 32'h00000000, "R5 signed div zero", 0);
    run_op(2'b11, 32'h1234ABCD, 32'h00000000, "R5 unsigned div zero", 0);
    run_op(2'b00, 32'hFFFF0001, 32'h0000FFFF, "R7 start while busy", 1);
    run_op(2'b11, 32'hDEADBEEF, 32'h00001234, "R7 div with poke", 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule